// File: doc/BRIEF.md
# Single-Dword Read Completion Generator

This block serves the read side of a memory-mapped completer inside a PCIe endpoint that exposes several physical and virtual functions. The request receiver hands it one decoded single-dword memory read. The block issues one read to a scratch memory that is partitioned by function and waits the fixed memory latency. It then holds the returned dword in a register and transmits a single completion-with-data beat on a 256-bit AXI4-Stream master. The beat carries a three-dword completion descriptor and the one payload dword.

The descriptor names the responding function, so the host can tell which physical or virtual function answered. When the stream handshake completes, the block raises a one-cycle done pulse. The receiver uses that pulse to release its own stall. The block accepts no new request until the done pulse has been seen.

The controller has four states:

- **IDLE**: waits for a request.
  - Transition *accept*: `req_valid` is seen in IDLE, so the request is latched and the state moves to ISSUE.
- **ISSUE**: drives the memory read for one cycle.
  - Transition *issued*: always moves on to WAIT.
- **WAIT**: counts the memory latency and captures the data in its last cycle.
  - Transition *data_ready*: the latency has expired, so the state moves to SEND.
- **SEND**: presents the beat.
  - Transition *handshake*: `cpl_tready` is seen, so done pulses and the state returns to IDLE.

Top module: `cpl_dw_gen`

## Requirements
- R1: After reset, `cpl_tvalid`, `done` and `mem_rd_en` are low.
- R2: A request accepted at a clock edge drives `mem_rd_en` high for exactly the one following cycle. In that cycle `mem_rd_addr` is `{req_fn[6], req_fn[2:0], req_dw_addr}`, which gives functions 0x00 and 0x01 and the range 0x40 to 0x45 distinct memory regions.
- R3: The memory returns data in the cycle that comes MEM_LAT (default 2) cycles after the read cycle. The block captures the data in that cycle. `cpl_tvalid` rises in the cycle after the capture cycle, so it is high MEM_LAT+1 cycles after the read cycle.
- R4: The completion is one beat. `cpl_tlast` is 1, and `cpl_tkeep` is 0x0F, which marks the three descriptor dwords plus one payload dword. Payload bits [127:96] equal the memory word returned for the read.
- R5: While `cpl_tvalid` is high and `cpl_tready` is low, the beat stays valid and `cpl_tdata` does not change.
- R6: The following descriptor fields hold fixed values:

  | Field | Bits | Value |
  |---|---|---|
  | byte count | [28:16] | 4 |
  | dword count | [42:32] | 1 |
  | completion status | [45:43] | 0, successful |
  | address type | [9:8] | 0 |
  | locked | [29] | 0 |
  | poisoned | [46] | 0 |
  | bus | [87:80] | 0 |
  | force-ECRC | [95] | 0 |
  | upper lanes | [255:128] | 0 |
- R7: The descriptor echoes the request's requester ID in [63:48], its tag in [71:64], its traffic class in [91:89] and its attributes in [94:92].
- R8: The function field [79:72] holds `req_fn`, and the completer-ID-enable bit [88] is 0.
- R9: The lower-address field [6:0] is `{req_dw_addr[4:0], b}`. Here b is the index of the lowest set bit of `req_first_be`, and b is 0 when no bit is set.
- R10: `done` is high for exactly the cycle in which `cpl_tvalid` and `cpl_tready` are both high. Each accepted request yields exactly one completion.
- R11: `req_valid` is ignored outside IDLE, including in the cycle that `done` is high. A request held across that cycle is accepted at the next edge. A request presented while the block is busy does not alter the completion in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_fn | input | 8 | Target function number |
| req_dw_addr | input | DW_AW | Dword address within the function's window |
| req_first_be | input | 4 | First-dword byte enables |
| req_rid | input | 16 | Requester ID |
| req_tag | input | 8 | Request tag |
| req_tc | input | 3 | Traffic class |
| req_attr | input | 3 | Attributes |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | DW_AW+4 | Region and dword address for the read |
| mem_rd_data | input | 32 | Memory read data, valid MEM_LAT cycles after the strobe |
| cpl_tdata | output | TDATA_W | Completion beat |
| cpl_tkeep | output | TDATA_W/32 | Dword-granular keep |
| cpl_tlast | output | 1 | Last beat |
| cpl_tvalid | output | 1 | Beat valid |
| cpl_tready | input | 1 | Downstream ready |
| done | output | 1 | Completion sent, one cycle |

## Verification
The completion handshake (done) and the acceptance of a new request can fall in the same cycle. The bench provokes this by keeping `req_valid` high, with the fields of a second request, through the whole of a first transaction. It judges the outcome on four points:

- `mem_rd_en` stays low through the `done` cycle and the cycle after it.
- The second read is issued only in the following cycle, with the second request's address.
- The first completion still carries the first request's fields.
- The second completion carries the second request's fields.

Back-pressure on `cpl_tready` is applied at the same time as a beat is pending, and the beat is checked to stay unchanged.

// File: rtl/cpl_pkg.sv
package cpl_pkg;

    // Controller states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_SEND  = 2'd3
    } cpl_state_e;

    // Header fields of a request carried through to the completion
    typedef struct packed {
        logic [7:0]  fn;
        logic [3:0]  first_be;
        logic [15:0] rid;
        logic [7:0]  tag;
        logic [2:0]  tc;
        logic [2:0]  attr;
    } cpl_hdr_t;

    // Completion descriptor field positions (decoded downstream)
    localparam int LA_LO    = 0;
    localparam int LA_W     = 7;
    localparam int AT_LO    = 8;
    localparam int BC_LO    = 16;
    localparam int BC_W     = 13;
    localparam int LOCK_BIT = 29;
    localparam int DC_LO    = 32;
    localparam int DC_W     = 11;
    localparam int ST_LO    = 43;
    localparam int POIS_BIT = 46;
    localparam int RID_LO   = 48;
    localparam int TAG_LO   = 64;
    localparam int FN_LO    = 72;
    localparam int BUS_LO   = 80;
    localparam int CIDE_BIT = 88;
    localparam int TC_LO    = 89;
    localparam int ATTR_LO  = 92;
    localparam int ECRC_BIT = 95;
    localparam int PAY_LO   = 96;
    localparam int DESC_DW  = 3;

    // Byte offset of the first enabled byte
    function automatic logic [1:0] first_byte(input logic [3:0] be);
        logic [1:0] r;
        r = 2'd0;
        for (int i = 3; i >= 0; i--) begin
            if (be[i]) r = 2'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/cpl_req_hold.sv
module cpl_req_hold
    import cpl_pkg::*;
#(
    parameter int DW_AW = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  cpl_hdr_t         hdr_in,
    input  logic [DW_AW-1:0] addr_in,
    output cpl_hdr_t         hdr_q,
    output logic [DW_AW-1:0] addr_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_q  <= '0;
            addr_q <= '0;
        end else if (load) begin
            hdr_q  <= hdr_in;
            addr_q <= addr_in;
        end
    end

endmodule

// File: rtl/cpl_lat_timer.sv
module cpl_lat_timer #(
    parameter int MEM_LAT = 2,
    localparam int CW     = $clog2(MEM_LAT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expired
);

    localparam logic [CW-1:0] LAT_C = CW'(MEM_LAT);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CW'(1);
        end else if (run && cnt_q != LAT_C) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign expired = run && (cnt_q == LAT_C);

    // R3: while waiting, the count stays within 1..MEM_LAT
    a_r3_count_window: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q != '0 && cnt_q <= LAT_C));

endmodule

// File: rtl/cpl_desc_pack.sv
module cpl_desc_pack
    import cpl_pkg::*;
#(
    parameter int DW_AW   = 9,
    parameter int TDATA_W = 256,
    localparam int KEEP_W = TDATA_W / 32
) (
    input  cpl_hdr_t         hdr,
    input  logic [DW_AW-1:0] dw_addr,
    input  logic [31:0]      payload,
    output logic [TDATA_W-1:0] beat,
    output logic [KEEP_W-1:0]  keep
);

    always_comb begin
        beat = '0;
        beat[LA_LO +: LA_W]   = {dw_addr[4:0], first_byte(hdr.first_be)};
        beat[AT_LO +: 2]      = 2'b00;
        beat[BC_LO +: BC_W]   = BC_W'(4);
        beat[LOCK_BIT]        = 1'b0;
        beat[DC_LO +: DC_W]   = DC_W'(1);
        beat[ST_LO +: 3]      = 3'b000;
        beat[POIS_BIT]        = 1'b0;
        beat[RID_LO +: 16]    = hdr.rid;
        beat[TAG_LO +: 8]     = hdr.tag;
        beat[FN_LO +: 8]      = hdr.fn;
        beat[BUS_LO +: 8]     = 8'h00;
        beat[CIDE_BIT]        = 1'b0;
        beat[TC_LO +: 3]      = hdr.tc;
        beat[ATTR_LO +: 3]    = hdr.attr;
        beat[ECRC_BIT]        = 1'b0;
        beat[PAY_LO +: 32]    = payload;
    end

    for (genvar i = 0; i < KEEP_W; i++) begin : g_keep
        assign keep[i] = (i <= DESC_DW) ? 1'b1 : 1'b0;
    end

endmodule

// File: rtl/cpl_dw_gen.sv
module cpl_dw_gen
    import cpl_pkg::*;
#(
    parameter int DW_AW   = 9,
    parameter int MEM_LAT = 2,
    parameter int TDATA_W = 256,
    localparam int MEM_AW = DW_AW + 4,
    localparam int KEEP_W = TDATA_W / 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [7:0]         req_fn,
    input  logic [DW_AW-1:0]   req_dw_addr,
    input  logic [3:0]         req_first_be,
    input  logic [15:0]        req_rid,
    input  logic [7:0]         req_tag,
    input  logic [2:0]         req_tc,
    input  logic [2:0]         req_attr,
    output logic               mem_rd_en,
    output logic [MEM_AW-1:0]  mem_rd_addr,
    input  logic [31:0]        mem_rd_data,
    output logic [TDATA_W-1:0] cpl_tdata,
    output logic [KEEP_W-1:0]  cpl_tkeep,
    output logic               cpl_tlast,
    output logic               cpl_tvalid,
    input  logic               cpl_tready,
    output logic               done
);

    cpl_state_e state_q, state_d;
    cpl_hdr_t   hdr_in, hdr_q;
    logic [DW_AW-1:0] addr_q;
    logic [31:0] data_q;
    logic        accept, lat_load, lat_run, lat_exp;

    assign hdr_in = '{fn: req_fn, first_be: req_first_be, rid: req_rid,
                      tag: req_tag, tc: req_tc, attr: req_attr};
    assign accept = (state_q == ST_IDLE) && req_valid;

    cpl_req_hold #(.DW_AW(DW_AW)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .hdr_in  (hdr_in),
        .addr_in (req_dw_addr),
        .hdr_q   (hdr_q),
        .addr_q  (addr_q)
    );

    assign lat_load = (state_q == ST_ISSUE);
    assign lat_run  = (state_q == ST_WAIT);

    cpl_lat_timer #(.MEM_LAT(MEM_LAT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (lat_load),
        .run     (lat_run),
        .expired (lat_exp)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: accept, issued, data_ready, handshake
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid)  state_d = ST_ISSUE;
            ST_ISSUE:                 state_d = ST_WAIT;
            ST_WAIT:  if (lat_exp)    state_d = ST_SEND;
            ST_SEND:  if (cpl_tready) state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        mem_rd_en   = (state_q == ST_ISSUE);
        mem_rd_addr = {hdr_q.fn[6], hdr_q.fn[2:0], addr_q};
        cpl_tvalid  = (state_q == ST_SEND);
        cpl_tlast   = (state_q == ST_SEND);
        done        = (state_q == ST_SEND) && cpl_tready;
    end

    // Read-data holding register
    always_ff @(posedge clk) begin
        if (!rst_n)       data_q <= '0;
        else if (lat_exp) data_q <= mem_rd_data;
    end

    cpl_desc_pack #(.DW_AW(DW_AW), .TDATA_W(TDATA_W)) u_pack (
        .hdr     (hdr_q),
        .dw_addr (addr_q),
        .payload (data_q),
        .beat    (cpl_tdata),
        .keep    (cpl_tkeep)
    );

    // R2: the memory strobe lasts one cycle
    a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);

    // R5: a stalled beat holds
    a_r5_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_tvalid && !cpl_tready) |=> (cpl_tvalid && $stable(cpl_tdata)));

    // R10: done only with a handshake, never two cycles running
    a_r10_done_handshake: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cpl_tvalid && cpl_tready));
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: no read while a beat is pending or in the cycle after done
    a_r11_no_read_busy: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_tvalid |-> !mem_rd_en);
    a_r11_no_read_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !mem_rd_en);

endmodule

// File: tb/sim_cpl_dw_gen.sv
module sim_cpl_dw_gen;

    localparam int CLK_PERIOD = 10;
    localparam int DW_AW      = 9;
    localparam int MEM_LAT    = 2;
    localparam int TDATA_W    = 256;

    typedef struct packed {
        logic [7:0]  fn;
        logic [8:0]  addr;
        logic [3:0]  be;
        logic [15:0] rid;
        logic [7:0]  tag;
        logic [2:0]  tc;
        logic [2:0]  attr;
        logic [3:0]  stall;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{8'h00, 9'h001, 4'b1111, 16'h0100, 8'h01, 3'd0, 3'd0, 4'd0},
        '{8'h01, 9'h1FF, 4'b0010, 16'h0208, 8'h7F, 3'd3, 3'd2, 4'd2},
        '{8'h40, 9'h000, 4'b0100, 16'h1234, 8'h80, 3'd7, 3'd7, 4'd0},
        '{8'h45, 9'h0AA, 4'b1000, 16'hFFFF, 8'hFF, 3'd1, 3'd4, 4'd3},
        '{8'h43, 9'h155, 4'b0000, 16'h0001, 8'h00, 3'd5, 3'd1, 4'd1},
        '{8'h44, 9'h010, 4'b1100, 16'hBEEF, 8'h3C, 3'd2, 3'd6, 4'd0}
    };

    logic clk = 0, rst_n = 0;
    logic req_valid = 0;
    logic [7:0] req_fn = 0;
    logic [DW_AW-1:0] req_dw_addr = 0;
    logic [3:0] req_first_be = 0;
    logic [15:0] req_rid = 0;
    logic [7:0] req_tag = 0;
    logic [2:0] req_tc = 0, req_attr = 0;
    logic mem_rd_en;
    logic [DW_AW+3:0] mem_rd_addr;
    logic [31:0] mem_rd_data;
    logic [TDATA_W-1:0] cpl_tdata;
    logic [7:0] cpl_tkeep;
    logic cpl_tlast, cpl_tvalid, done;
    logic cpl_tready = 0;

    int n_chk = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpl_dw_gen #(.DW_AW(DW_AW), .MEM_LAT(MEM_LAT), .TDATA_W(TDATA_W)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_fn(req_fn),
        .req_dw_addr(req_dw_addr), .req_first_be(req_first_be), .req_rid(req_rid),
        .req_tag(req_tag), .req_tc(req_tc), .req_attr(req_attr),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .cpl_tdata(cpl_tdata), .cpl_tkeep(cpl_tkeep), .cpl_tlast(cpl_tlast),
        .cpl_tvalid(cpl_tvalid), .cpl_tready(cpl_tready), .done(done)
    );

    // Memory model: content computed from the address, two-stage latency
    function automatic logic [31:0] memf(input logic [DW_AW+3:0] a);
        return 32'hA500_0000 ^ (32'(a) * 32'h9E37_79B1);
    endfunction

    logic s1_v = 0, s2_v = 0;
    logic [31:0] s1_d = 0, s2_d = 0;
    always @(posedge clk) begin
        s1_v <= mem_rd_en;
        s1_d <= memf(mem_rd_addr);
        s2_v <= s1_v;
        s2_d <= s1_d;
    end
    assign mem_rd_data = s2_v ? s2_d : 32'hDEAD_BEEF;

    task automatic chk(input bit ok, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [DW_AW+3:0] exp_maddr(input vec_t v);
        return {v.fn[6], v.fn[2:0], v.addr};
    endfunction

    function automatic logic [6:0] exp_low(input vec_t v);
        logic [1:0] b;
        casez (v.be)
            4'b???1: b = 2'd0;
            4'b??10: b = 2'd1;
            4'b?100: b = 2'd2;
            4'b1000: b = 2'd3;
            default: b = 2'd0;
        endcase
        return {v.addr[4:0], b};
    endfunction

    function automatic logic [255:0] exp_beat(input vec_t v);
        logic [255:0] e;
        e = '0;
        e[6:0]   = exp_low(v);
        e[28:16] = 13'd4;
        e[42:32] = 11'd1;
        e[63:48] = v.rid;
        e[71:64] = v.tag;
        e[79:72] = v.fn;
        e[91:89] = v.tc;
        e[94:92] = v.attr;
        e[127:96] = memf(exp_maddr(v));
        return e;
    endfunction

    task automatic drive(input vec_t v);
        req_fn = v.fn; req_dw_addr = v.addr; req_first_be = v.be;
        req_rid = v.rid; req_tag = v.tag; req_tc = v.tc; req_attr = v.attr;
    endtask

    // Called at the negedge of the read cycle; finishes the completion
    task automatic finish_txn(input vec_t v);
        logic [255:0] held;
        int n;
        chk(mem_rd_en === 1'b1, "R2 strobe", 256'(mem_rd_en), 256'(1));
        chk(mem_rd_addr === exp_maddr(v), "R2 address", 256'(mem_rd_addr),
            256'(exp_maddr(v)));
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (!cpl_tvalid)
                chk(mem_rd_en === 1'b0 && done === 1'b0, "R2 strobe once",
                    256'(mem_rd_en), 256'(0));
        end while (!cpl_tvalid && n < 10);
        chk(n == MEM_LAT + 1, "R3 latency", 256'(n), 256'(MEM_LAT + 1));
        held = cpl_tdata;
        for (int s = 0; s < int'(v.stall); s++) begin
            @(negedge clk);
            chk(cpl_tvalid === 1'b1 && cpl_tdata === held && done === 1'b0,
                "R5 stall hold", cpl_tdata, held);
        end
        cpl_tready = 1;
        #1;
        chk(done === 1'b1, "R10 done on handshake", 256'(done), 256'(1));
        chk(cpl_tlast === 1'b1 && cpl_tkeep === 8'h0F, "R4 single beat keep/last",
            256'({cpl_tlast, cpl_tkeep}), 256'({1'b1, 8'h0F}));
        chk(cpl_tdata[127:96] === memf(exp_maddr(v)), "R4 payload",
            256'(cpl_tdata[127:96]), 256'(memf(exp_maddr(v))));
        chk(cpl_tdata[79:72] === v.fn && cpl_tdata[88] === 1'b0, "R8 function/cid",
            256'(cpl_tdata[88:72]), 256'({1'b0, 8'h00, v.fn}));
        chk(cpl_tdata[6:0] === exp_low(v), "R9 lower address",
            256'(cpl_tdata[6:0]), 256'(exp_low(v)));
        chk(cpl_tdata === exp_beat(v), "R6 R7 full descriptor", cpl_tdata, exp_beat(v));
        @(negedge clk);
        cpl_tready = 0;
        chk(cpl_tvalid === 1'b0 && done === 1'b0, "R10 one completion",
            256'({cpl_tvalid, done}), 256'(0));
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        vec_t a, b;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(cpl_tvalid === 1'b0 && done === 1'b0 && mem_rd_en === 1'b0, "R1 reset",
            256'({cpl_tvalid, done, mem_rd_en}), 256'(0));
        rst_n = 1;
        @(negedge clk);
        chk(cpl_tvalid === 1'b0 && mem_rd_en === 1'b0, "R1 idle after reset",
            256'({cpl_tvalid, mem_rd_en}), 256'(0));

        // Vector table
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            req_valid = 1;
            @(negedge clk);
            req_valid = 0;
            finish_txn(VECS[i]);
            @(negedge clk);
        end

        // R11: request held through a whole transaction and its done cycle
        a = VECS[3];
        b = VECS[1];
        drive(a);
        req_valid = 1;
        @(negedge clk);
        drive(b);
        chk(mem_rd_en === 1'b1 && mem_rd_addr === exp_maddr(a), "R11 first read",
            256'(mem_rd_addr), 256'(exp_maddr(a)));
        while (!cpl_tvalid) @(negedge clk);
        chk(cpl_tdata === exp_beat(a), "R11 fields not disturbed while busy",
            cpl_tdata, exp_beat(a));
        cpl_tready = 1;
        #1;
        chk(done === 1'b1 && mem_rd_en === 1'b0, "R11 done cycle no read",
            256'({done, mem_rd_en}), 256'({1'b1, 1'b0}));
        @(negedge clk);
        cpl_tready = 0;
        chk(mem_rd_en === 1'b0, "R11 no read right after done", 256'(mem_rd_en), 256'(0));
        @(negedge clk);
        req_valid = 0;
        finish_txn(b);

        // R11: pulse while busy is dropped
        drive(VECS[0]);
        req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        @(negedge clk);
        drive(VECS[5]);
        req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        while (!cpl_tvalid) @(negedge clk);
        cpl_tready = 1;
        @(negedge clk);
        cpl_tready = 0;
        repeat (6) begin
            @(negedge clk);
            chk(mem_rd_en === 1'b0 && cpl_tvalid === 1'b0, "R11 busy pulse ignored",
                256'({mem_rd_en, cpl_tvalid}), 256'(0));
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule